// File: doc/BRIEF.md
# Dual-Slot Receive Frame Buffer

This block takes an incoming Ethernet frame as a byte stream and files it into one of two receive slots of `SLOT_BYTES` bytes each (2048 by default). Each slot carries a small state register, so ownership passes back and forth between software and hardware. Software arms a slot by writing the loaded code. The block fills the first armed slot and then hands it back to software by marking it pending. Software reads the stored image through the slot memory port, which it observes. It then writes the state back to empty or loaded.

The image stored in a slot holds more than the frame data. Offsets 0 to 7 hold a generated preamble and start-of-frame delimiter. The frame data starts at offset 8 and is zero-padded to a minimum length. A CRC-32 frame check sequence follows the padded data. The count register records the total size of the image.

The filler is a state machine with seven states:
- IDLE waits for a start marker.
- STORE writes data bytes.
- DROP swallows a frame that has no armed slot.
- PAD writes zero bytes.
- FCS writes the four check bytes.
- PRE writes the eight leading bytes.
- COMMIT updates the slot registers.

Its transitions are:
- IDLE→STORE on a start byte while a slot is loaded.
- IDLE→PAD when that start byte is also the end byte.
- IDLE→DROP on a start byte with no slot loaded.
- IDLE stays in IDLE when a start-and-end byte arrives with no slot loaded.
- STORE→PAD on the end byte when the frame is short.
- STORE→FCS on the end byte when the frame is long enough.
- STORE→IDLE on the end byte of an oversize frame (reject).
- DROP→IDLE on the end byte.
- PAD→FCS once the minimum length is reached.
- FCS→PRE after the fourth check byte.
- PRE→COMMIT after the eighth leading byte.
- COMMIT→IDLE.

Top module: `rx_dual_slot_buf`

## Requirements
- R1: After reset both slot states read 0 (empty), both counts read 0, and `rx_irq` and `ready` are low. State codes are 0 = empty, 1 = loaded (armed for hardware), 2 = pending (frame stored for software).
- R2: A frame begins on a byte with `in_valid` and `in_sof` both high. At that byte the block selects slot 0 if its state is 1, otherwise slot 1 if its state is 1. If neither slot is loaded, the whole frame is discarded with no memory write (`mem_slot` 0 = slot 0, 1 = slot 1).
- R3: In the selected slot, offsets 0 to 6 receive 0x55 and offset 7 receives 0xD5. Data byte k is written at offset 8+k.
- R4: A frame of fewer than `MIN_DATA` (60) data bytes is followed by zero bytes up to 60 data bytes. A frame of 60 bytes or more gets no padding.
- R5: Right after the padded data, the block writes a CRC-32 over the padded data, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones and is inverted at the end.
- R6: A frame whose data length exceeds `SLOT_BYTES`-12 (2036) is rejected. Its slot keeps state 1 and its count is unchanged. A frame of exactly 2036 bytes is accepted.
- R7: On acceptance, the slot count becomes the padded data length plus 12, and the slot state becomes 2.
- R8: `rx_irq` is high exactly while either state is 2. It follows a software state write in the cycle after that write.
- R9: `ready` is high exactly while at least one slot state is 1.
- R10: Register writes use `reg_addr` 0 = state of slot 0, 1 = count of slot 0, 2 = state of slot 1, 3 = count of slot 1. A state write keeps `reg_wdata[1:0]`, and a count write keeps the low count bits. A hardware commit wins over a software write to the same slot in the same cycle.
- R11: Bytes arriving in IDLE without a start marker are ignored and cause no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Input byte |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| mem_we | output | 1 | Slot memory write enable |
| mem_slot | output | 1 | Slot being written |
| mem_addr | output | $clog2(SLOT_BYTES) | Byte offset in the slot |
| mem_data | output | 8 | Byte written |
| state0 | output | 2 | Slot 0 state |
| count0 | output | $clog2(SLOT_BYTES)+1 | Slot 0 stored size |
| state1 | output | 2 | Slot 1 state |
| count1 | output | $clog2(SLOT_BYTES)+1 | Slot 1 stored size |
| rx_irq | output | 1 | Receive interrupt (level) |
| ready | output | 1 | A slot is armed |

## Verification
The assertions check three things on every cycle. First, any write to offsets 0 to 7 carries the fixed leading pattern. Second, a count changes only by a software write to it or together with its slot turning pending. Third, a slot that turns pending without a software write holds a count between the padded minimum and the slot size. The bench scenarios cover the rest: byte-exact slot contents, padding, CRC values, slot priority, dropping and rejection, and the interrupt and ready levels under software writes. Only a full stream checked against independently computed images can show these.

// File: rtl/rxsb_pkg.sv
package rxsb_pkg;

    localparam logic [1:0] SLOT_EMPTY   = 2'd0;
    localparam logic [1:0] SLOT_LOADED  = 2'd1;
    localparam logic [1:0] SLOT_PENDING = 2'd2;

    typedef enum logic [2:0] {
        F_IDLE,
        F_STORE,
        F_DROP,
        F_PAD,
        F_FCS,
        F_PRE,
        F_COMMIT
    } fill_st_e;

    function automatic logic [31:0] crc32_byte(input logic [31:0] c_in,
                                               input logic [7:0]  d);
        logic [31:0] c;
        c = c_in;
        for (int b = 0; b < 8; b++) begin
            if ((c[0] ^ d[b]) == 1'b1) c = (c >> 1) ^ 32'hEDB8_8320;
            else                       c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/rx_fill_fsm.sv
module rx_fill_fsm
    import rxsb_pkg::*;
#(
    parameter int SLOT_BYTES = 2048,
    parameter int MIN_DATA   = 60,
    localparam int AW = $clog2(SLOT_BYTES),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_eof,
    input  logic [7:0]    in_data,
    input  logic          slot0_loaded,
    input  logic          slot1_loaded,
    output logic          mem_we,
    output logic          mem_slot,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_data,
    output logic          commit,
    output logic          commit_slot,
    output logic [CW-1:0] commit_count
);
    localparam int PRE_BYTES = 8;
    localparam int FCS_BYTES = 4;
    localparam int OVERHEAD  = PRE_BYTES + FCS_BYTES;
    localparam int MAX_DATA  = SLOT_BYTES - OVERHEAD;

    fill_st_e      st, nxt;
    logic [CW-1:0] len;
    logic [31:0]   crc;
    logic [2:0]    idx;
    logic          slot;
    logic          ovf;
    logic          any_loaded;
    logic          start;
    logic [31:0]   crc_sh;

    assign any_loaded = slot0_loaded | slot1_loaded;
    assign start      = in_valid & in_sof;
    assign crc_sh     = ~crc >> {idx[1:0], 3'b000};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= F_IDLE;
        else        st <= nxt;
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            F_IDLE: begin
                if (start) begin
                    if (any_loaded) nxt = in_eof ? F_PAD : F_STORE;
                    else            nxt = in_eof ? F_IDLE : F_DROP;
                end
            end
            F_STORE: begin
                if (in_valid && in_eof) begin
                    if (ovf || len >= CW'(MAX_DATA))        nxt = F_IDLE;
                    else if (len + CW'(1) < CW'(MIN_DATA))  nxt = F_PAD;
                    else                                    nxt = F_FCS;
                end
            end
            F_DROP:   if (in_valid && in_eof) nxt = F_IDLE;
            F_PAD:    if (len + CW'(1) >= CW'(MIN_DATA)) nxt = F_FCS;
            F_FCS:    if (idx == 3'(FCS_BYTES - 1)) nxt = F_PRE;
            F_PRE:    if (idx == 3'(PRE_BYTES - 1)) nxt = F_COMMIT;
            F_COMMIT: nxt = F_IDLE;
            default:  nxt = F_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len  <= '0;
            crc  <= '1;
            idx  <= '0;
            slot <= 1'b0;
            ovf  <= 1'b0;
        end else begin
            unique case (st)
                F_IDLE: begin
                    if (start && any_loaded) begin
                        slot <= ~slot0_loaded;
                        len  <= CW'(1);
                        crc  <= crc32_byte('1, in_data);
                        ovf  <= 1'b0;
                        idx  <= '0;
                    end
                end
                F_STORE: begin
                    if (in_valid) begin
                        if (len < CW'(MAX_DATA)) begin
                            len <= len + CW'(1);
                            crc <= crc32_byte(crc, in_data);
                        end else begin
                            ovf <= 1'b1;
                        end
                    end
                end
                F_PAD: begin
                    len <= len + CW'(1);
                    crc <= crc32_byte(crc, 8'h00);
                end
                F_FCS:    idx <= (idx == 3'(FCS_BYTES - 1)) ? 3'd0 : idx + 3'd1;
                F_PRE:    idx <= idx + 3'd1;
                F_DROP, F_COMMIT: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_we       = 1'b0;
        mem_slot     = slot;
        mem_addr     = AW'(len + CW'(PRE_BYTES));
        mem_data     = in_data;
        commit       = 1'b0;
        commit_slot  = slot;
        commit_count = len + CW'(OVERHEAD);
        unique case (st)
            F_IDLE: begin
                mem_we   = start & any_loaded;
                mem_slot = ~slot0_loaded;
                mem_addr = AW'(PRE_BYTES);
            end
            F_STORE:  mem_we = in_valid && (len < CW'(MAX_DATA));
            F_PAD: begin
                mem_we   = 1'b1;
                mem_data = 8'h00;
            end
            F_FCS: begin
                mem_we   = 1'b1;
                mem_addr = AW'(len + CW'(PRE_BYTES) + CW'(idx));
                mem_data = crc_sh[7:0];
            end
            F_PRE: begin
                mem_we   = 1'b1;
                mem_addr = AW'(idx);
                mem_data = (idx == 3'(PRE_BYTES - 1)) ? 8'hD5 : 8'h55;
            end
            F_COMMIT: commit = 1'b1;
            F_DROP: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/rx_slot_regs.sv
module rx_slot_regs
    import rxsb_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    input  logic          commit,
    input  logic          commit_slot,
    input  logic [CW-1:0] commit_count,
    output logic [1:0]    state0,
    output logic [1:0]    state1,
    output logic [CW-1:0] count0,
    output logic [CW-1:0] count1,
    output logic          slot0_loaded,
    output logic          slot1_loaded,
    output logic          rx_irq,
    output logic          ready
);
    localparam int NSLOT = 2;

    logic [1:0]    st_q  [NSLOT];
    logic [CW-1:0] cnt_q [NSLOT];
    logic          unused_wdata_bits;

    assign unused_wdata_bits = ^reg_wdata[31:CW];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic hw_hit;
        assign hw_hit = commit && (commit_slot == 1'(g));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]  <= SLOT_EMPTY;
                cnt_q[g] <= '0;
            end else if (hw_hit) begin
                st_q[g]  <= SLOT_PENDING;
                cnt_q[g] <= commit_count;
            end else if (reg_we && reg_addr[1] == 1'(g)) begin
                if (reg_addr[0]) cnt_q[g] <= reg_wdata[CW-1:0];
                else             st_q[g]  <= reg_wdata[1:0];
            end
        end
    end

    assign state0       = st_q[0];
    assign state1       = st_q[1];
    assign count0       = cnt_q[0];
    assign count1       = cnt_q[1];
    assign slot0_loaded = (st_q[0] == SLOT_LOADED);
    assign slot1_loaded = (st_q[1] == SLOT_LOADED);
    assign ready        = slot0_loaded | slot1_loaded;
    assign rx_irq       = (st_q[0] == SLOT_PENDING) | (st_q[1] == SLOT_PENDING);

endmodule

// File: rtl/rx_dual_slot_buf.sv
module rx_dual_slot_buf #(
    parameter int SLOT_BYTES = 2048,
    parameter int MIN_DATA   = 60
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic                         in_sof,
    input  logic                         in_eof,
    input  logic [7:0]                   in_data,
    input  logic                         reg_we,
    input  logic [1:0]                   reg_addr,
    input  logic [31:0]                  reg_wdata,
    output logic                         mem_we,
    output logic                         mem_slot,
    output logic [$clog2(SLOT_BYTES)-1:0] mem_addr,
    output logic [7:0]                   mem_data,
    output logic [1:0]                   state0,
    output logic [$clog2(SLOT_BYTES):0]  count0,
    output logic [1:0]                   state1,
    output logic [$clog2(SLOT_BYTES):0]  count1,
    output logic                         rx_irq,
    output logic                         ready
);
    localparam int AW = $clog2(SLOT_BYTES);
    localparam int CW = AW + 1;

    logic          slot0_loaded, slot1_loaded;
    logic          commit, commit_slot;
    logic [CW-1:0] commit_count;

    rx_fill_fsm #(.SLOT_BYTES(SLOT_BYTES), .MIN_DATA(MIN_DATA)) u_fill (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .slot0_loaded(slot0_loaded), .slot1_loaded(slot1_loaded),
        .mem_we(mem_we), .mem_slot(mem_slot), .mem_addr(mem_addr), .mem_data(mem_data),
        .commit(commit), .commit_slot(commit_slot), .commit_count(commit_count)
    );

    rx_slot_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .commit(commit), .commit_slot(commit_slot), .commit_count(commit_count),
        .state0(state0), .state1(state1), .count0(count0), .count1(count1),
        .slot0_loaded(slot0_loaded), .slot1_loaded(slot1_loaded),
        .rx_irq(rx_irq), .ready(ready)
    );

endmodule

// File: rtl/rx_dual_slot_buf_chk.sv
module rx_dual_slot_buf_chk #(
    parameter int SLOT_BYTES = 2048,
    parameter int MIN_DATA   = 60,
    localparam int AW = $clog2(SLOT_BYTES),
    localparam int CW = AW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [1:0]    reg_addr,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    mem_data,
    input logic [1:0]    state0,
    input logic [1:0]    state1,
    input logic [CW-1:0] count0,
    input logic [CW-1:0] count1
);
    // R3
    sfd_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr == AW'(7)) |-> mem_data == 8'hD5);

    // R3
    pre_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr < AW'(7)) |-> mem_data == 8'h55);

    // R7
    commit_len0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(state0 == 2'd2) && !$past(reg_we && reg_addr == 2'd0)) |->
        (count0 >= CW'(MIN_DATA + 12) && count0 <= CW'(SLOT_BYTES)));

    // R7
    commit_len1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(state1 == 2'd2) && !$past(reg_we && reg_addr == 2'd2)) |->
        (count1 >= CW'(MIN_DATA + 12) && count1 <= CW'(SLOT_BYTES)));

    // R10
    count0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count0) |->
        ($past(reg_we && reg_addr == 2'd1) || (state0 == 2'd2 && $past(state0) != 2'd2)));

    // R10
    count1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count1) |->
        ($past(reg_we && reg_addr == 2'd3) || (state1 == 2'd2 && $past(state1) != 2'd2)));

endmodule

bind rx_dual_slot_buf rx_dual_slot_buf_chk #(.SLOT_BYTES(SLOT_BYTES), .MIN_DATA(MIN_DATA)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .state0(state0), .state1(state1), .count0(count0), .count1(count1)
);

// File: tb/sim_rx_dual_slot_buf.sv
`timescale 1ns/1ps
module sim_rx_dual_slot_buf;
    localparam int SB = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        mem_we, mem_slot;
    logic [10:0] mem_addr;
    logic [7:0]  mem_data;
    logic [1:0]  state0, state1;
    logic [11:0] count0, count1;
    logic        rx_irq, ready;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [7:0] shadow [SB];
    int         wr_cnt;
    logic [1:0] slot_mask;

    always #10 clk = ~clk;

    rx_dual_slot_buf u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_data(in_data), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .mem_we(mem_we), .mem_slot(mem_slot), .mem_addr(mem_addr), .mem_data(mem_data),
        .state0(state0), .count0(count0), .state1(state1), .count1(count1),
        .rx_irq(rx_irq), .ready(ready)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            shadow[mem_addr] <= mem_data;
            wr_cnt           <= wr_cnt + 1;
            slot_mask[mem_slot] <= 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pbyte(input int seed, input int k);
        return 8'((seed + k * 7) ^ (k >> 3));
    endfunction

    function automatic logic [31:0] ref_crc(input int n, input int seed);
        logic [31:0] c = 32'hFFFF_FFFF;
        int tot = (n < 60) ? 60 : n;
        for (int k = 0; k < tot; k++) begin
            logic [7:0] b = (k < n) ? pbyte(seed, k) : 8'h00;
            for (int j = 0; j < 8; j++) begin
                if ((c[0] ^ b[j]) == 1'b1) c = (c >> 1) ^ 32'hEDB8_8320;
                else                       c = c >> 1;
            end
        end
        return ~c;
    endfunction

    task automatic clear_capture();
        @(negedge clk);
        for (int i = 0; i < SB; i++) shadow[i] = 8'hEE;
        wr_cnt    = 0;
        slot_mask = 2'b00;
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic send_frame(input int n, input int seed, input bit with_sof);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = with_sof && (k == 0);
            in_eof   = (k == n - 1);
            in_data  = pbyte(seed, k);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        repeat (100) @(negedge clk);
    endtask

    task automatic check_image(input int n, input int seed);
        int tot = (n < 60) ? 60 : n;
        int bad_pre = 0, bad_dat = 0, bad_pad = 0, bad_fcs = 0;
        logic [31:0] fcs = ref_crc(n, seed);
        for (int i = 0; i < 8; i++)
            if (shadow[i] !== ((i == 7) ? 8'hD5 : 8'h55)) bad_pre++;
        for (int k = 0; k < n; k++)
            if (shadow[8 + k] !== pbyte(seed, k)) bad_dat++;
        for (int k = n; k < tot; k++)
            if (shadow[8 + k] !== 8'h00) bad_pad++;
        for (int i = 0; i < 4; i++)
            if (shadow[8 + tot + i] !== fcs[8*i +: 8]) bad_fcs++;
        chk(bad_pre == 0, "R3 preamble/SFD bytes", bad_pre, 0);
        chk(bad_dat == 0, "R3 data at offset 8", bad_dat, 0);
        chk(bad_pad == 0, "R4 zero padding", bad_pad, 0);
        chk(bad_fcs == 0, "R5 FCS bytes", bad_fcs, 0);
    endtask

    task automatic t_reset();
        chk(state0 == 2'd0 && state1 == 2'd0, "R1 reset states", {state1, state0}, 0);
        chk(count0 == 0 && count1 == 0, "R1 reset counts", {count1, count0}, 0);
        chk(rx_irq == 0, "R8 reset irq", rx_irq, 0);
        chk(ready == 0, "R9 reset ready", ready, 0);
    endtask

    task automatic t_drop();
        clear_capture();
        send_frame(30, 3, 1'b1);
        chk(wr_cnt == 0, "R2 drop without loaded slot", wr_cnt, 0);
        chk(state0 == 0 && state1 == 0, "R2 states untouched", {state1, state0}, 0);
    endtask

    task automatic t_no_sof();
        reg_wr(2'd0, 32'd1);
        chk(ready == 1, "R9 ready after loading", ready, 1);
        clear_capture();
        send_frame(10, 5, 1'b0);
        chk(wr_cnt == 0, "R11 bytes without start ignored", wr_cnt, 0);
        chk(state0 == 2'd1, "R11 slot stays loaded", state0, 1);
    endtask

    task automatic t_short_priority();
        reg_wr(2'd2, 32'd1);
        clear_capture();
        send_frame(20, 11, 1'b1);
        chk(slot_mask == 2'b01, "R2 slot 0 has priority", slot_mask, 1);
        chk(count0 == 12'd72, "R7 short count", count0, 72);
        chk(state0 == 2'd2, "R7 state pending", state0, 2);
        chk(rx_irq == 1, "R8 irq on pending", rx_irq, 1);
        chk(ready == 1, "R9 ready with slot 1 loaded", ready, 1);
        check_image(20, 11);
    endtask

    task automatic t_second_slot();
        clear_capture();
        send_frame(100, 42, 1'b1);
        chk(slot_mask == 2'b10, "R2 fallback to slot 1", slot_mask, 2);
        chk(count1 == 12'd112, "R7 long count", count1, 112);
        chk(state1 == 2'd2, "R7 slot 1 pending", state1, 2);
        chk(ready == 0, "R9 ready low, none loaded", ready, 0);
        check_image(100, 42);
    endtask

    task automatic t_sw_regs();
        reg_wr(2'd0, 32'd0);
        chk(rx_irq == 1, "R8 irq held by slot 1", rx_irq, 1);
        reg_wr(2'd2, 32'd0);
        chk(rx_irq == 0, "R8 irq cleared", rx_irq, 0);
        reg_wr(2'd1, 32'h5A);
        chk(count0 == 12'h5A, "R10 count write", count0, 'h5A);
        reg_wr(2'd0, 32'hFFFF_FFF5);
        chk(state0 == 2'd1, "R10 state keeps low two bits", state0, 1);
        chk(state1 == 2'd0, "R10 other slot untouched", state1, 0);
    endtask

    task automatic t_oversize();
        clear_capture();
        send_frame(2037, 9, 1'b1);
        chk(state0 == 2'd1, "R6 oversize keeps loaded", state0, 1);
        chk(count0 == 12'h5A, "R6 oversize count unchanged", count0, 'h5A);
        chk(rx_irq == 0, "R6 no irq on reject", rx_irq, 0);
    endtask

    task automatic t_max();
        clear_capture();
        send_frame(2036, 77, 1'b1);
        chk(state0 == 2'd2, "R6 max length accepted", state0, 2);
        chk(count0 == 12'd2048, "R7 max count", count0, 2048);
        check_image(2036, 77);
    endtask

    task automatic t_edges();
        reg_wr(2'd2, 32'd1);
        clear_capture();
        send_frame(60, 21, 1'b1);
        chk(count1 == 12'd72, "R4 exact 60 no pad", count1, 72);
        chk(wr_cnt == 72, "R4 exact 60 write count", wr_cnt, 72);
        check_image(60, 21);
        reg_wr(2'd2, 32'd1);
        clear_capture();
        send_frame(1, 99, 1'b1);
        chk(count1 == 12'd72, "R4 one-byte frame count", count1, 72);
        check_image(1, 99);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        wr_cnt = 0;
        slot_mask = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_drop();
        t_no_sof();
        t_short_priority();
        t_second_slot();
        t_sw_regs();
        t_oversize();
        t_max();
        t_edges();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule